// File: doc/BRIEF.md
# Chained Descriptor DMA Walker

The walker follows a list of four-word transfer descriptors held in system memory and turns each one into buffer requests for a separate data mover. It reads descriptors through a simple word-wide memory port. For each descriptor it issues an address and length request for each non-empty buffer and waits for the mover's done pulse. It then hands the descriptor back to software by clearing its ownership bit in memory, and moves on to the next descriptor. The actual data beats, the FIFO and the card side are outside this block.

Two list layouts are supported. In ring mode a descriptor carries two buffers, and the next descriptor follows after a programmable gap; an end-of-ring flag sends the walker back to the list base. In chained mode the fourth word is the address of the next descriptor. When the walker meets a descriptor it does not own, it parks itself and reports that the list has run dry. A poll strobe restarts it. Sticky flags report transmit completion, receive completion, an unavailable descriptor and a card error. A soft reset clears these flags.

Top module: `dsc_walker`

## Requirements
- R1: After `rst_ni` or a `soft_rst_i` pulse, `busy_o`, `mem_req_o`, `xfer_req_o` and all four flags are 0. The next start fetches its first descriptor from `base_addr_i`.
- R2: When idle with `enable_i`=1, a `poll_i` pulse makes the walker read the descriptor words at byte offsets +0, +4, +8 and +12 of the current address, in that order, one word per `mem_ack_i`. A poll while `enable_i`=0 starts nothing.
- R3: If word 0 is read with bit 31 (ownership) clear, the walker reads no further words and sets `dsc_unavail_o`. It stays busy (suspended). A later poll refetches the same descriptor from offset +0.
- R4: The buffer-1 request carries word 2 as its address and word 1 bits 12:0 as its length. The request is held until `xfer_done_i`.
- R5: In ring mode (word 0 bit 4 = 0), a buffer-2 request follows, with word 3 as its address and word 1 bits 25:13 as its length. In chained mode (bit 4 = 1), no buffer-2 request is issued.
- R6: A buffer with length 0 is skipped without any request. A length of 4096 is passed through unchanged.
- R7: After the buffers, the walker writes word 0 back to the descriptor address with bit 31 cleared and all other bits unchanged.
- R8: In ring mode, the next descriptor address is the current address + 16 + 4×`skip_words_i`. If word 0 bit 5 (end of ring) is set, the next address is `base_addr_i` instead.
- R9: In chained mode, the next descriptor address is word 3.
- R10: If word 0 bit 2 (last) is set, then after the write-back the walker goes idle. If bit 1 is also clear, it sets `tx_done_o` when `dir_tx_i`=1 and `rx_done_o` when `dir_tx_i`=0. If bit 2 is clear, the walker fetches the next descriptor without waiting for a poll. After going idle, the next poll continues from the advanced address.
- R11: An owned descriptor with word 0 bit 30 set raises `card_err_o`.
- R12: All flags stay set until a soft reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| enable_i | input | 1 | Allows a poll to start or resume the walk |
| soft_rst_i | input | 1 | Synchronous return to idle, clears flags, reloads base |
| poll_i | input | 1 | Poll-demand strobe |
| dir_tx_i | input | 1 | 1: transmit list, 0: receive list |
| base_addr_i | input | AW | Byte address of the first descriptor |
| skip_words_i | input | SKW | Words of gap between ring descriptors |
| mem_req_o | output | 1 | Memory access request |
| mem_we_o | output | 1 | 1: write, 0: read |
| mem_addr_o | output | AW | Byte address of the access |
| mem_wdata_o | output | 32 | Write data |
| mem_ack_i | input | 1 | Access completed; read data valid |
| mem_rdata_i | input | 32 | Read data |
| xfer_req_o | output | 1 | Buffer transfer request |
| xfer_addr_o | output | AW | Buffer address |
| xfer_len_o | output | 13 | Buffer length in bytes |
| xfer_done_i | input | 1 | Buffer transfer finished |
| busy_o | output | 1 | Walker not idle (includes suspended) |
| tx_done_o | output | 1 | Sticky transmit-complete flag |
| rx_done_o | output | 1 | Sticky receive-complete flag |
| dsc_unavail_o | output | 1 | Sticky unowned-descriptor flag |
| card_err_o | output | 1 | Sticky card-error flag |

## Verification
The assertions assume a well-behaved environment. `mem_ack_i` pulses only while `mem_req_o` is high, `xfer_done_i` pulses only while `xfer_req_o` is high, and a soft reset never lands in the same cycle as a handshake it would abandon. Under these conditions, held requests with stable addresses and flag edges that follow a write-back or a fetch are meaningful properties.

The bench memory acknowledges each request one cycle after it appears and then drops its acknowledge for a cycle. The mover model pulses done a few cycles after a request. Soft reset and poll are driven only while the walker is idle or suspended, so the stimulus stays inside those assumptions.

// File: rtl/dw_pkg.sv
package dw_pkg;
  localparam int DESC_WORDS = 4;
  localparam int SZ_W       = 13;
  // control word bit positions (decoded by software too)
  localparam int CB_INT_OFF = 1;
  localparam int CB_LAST    = 2;
  localparam int CB_CHAIN   = 4;
  localparam int CB_EOR     = 5;
  localparam int CB_CERR    = 30;
  localparam int CB_OWN     = 31;

  typedef enum logic [2:0] {
    ST_IDLE, ST_FETCH, ST_SUSP, ST_BUF1, ST_BUF2, ST_WB
  } walk_state_e;
endpackage

// File: rtl/dw_ptr.sv
module dw_ptr #(
  parameter int AW  = 32,
  parameter int SKW = 5
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          soft_rst_i,
  input  logic [AW-1:0] base_i,
  input  logic [SKW-1:0] skip_i,
  input  logic          start_i,
  input  logic          advance_i,
  input  logic          chain_i,
  input  logic          eor_i,
  input  logic [AW-1:0] next_ptr_i,
  output logic [AW-1:0] cur_o
);
  localparam int DESC_BYTES = 16;

  logic [AW-1:0] cur_q, next_d;
  logic          need_base_q;

  assign cur_o = need_base_q ? base_i : cur_q;

  always_comb begin
    if (chain_i)    next_d = next_ptr_i;
    else if (eor_i) next_d = base_i;
    else            next_d = cur_q + AW'(DESC_BYTES) + (AW'(skip_i) << 2);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cur_q       <= '0;
      need_base_q <= 1'b1;
    end else if (soft_rst_i) begin
      need_base_q <= 1'b1;
    end else if (start_i) begin
      cur_q       <= cur_o;
      need_base_q <= 1'b0;
    end else if (advance_i) begin
      cur_q       <= next_d;
    end
  end
endmodule

// File: rtl/dw_flags.sv
module dw_flags #(
  parameter int NF = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          soft_rst_i,
  input  logic [NF-1:0] set_i,
  output logic [NF-1:0] flag_o
);
  for (genvar g = 0; g < NF; g++) begin : g_flag
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)         flag_o[g] <= 1'b0;
      else if (soft_rst_i) flag_o[g] <= 1'b0;
      else if (set_i[g])   flag_o[g] <= 1'b1;
    end
  end
endmodule

// File: rtl/dsc_walker.sv
module dsc_walker
  import dw_pkg::*;
#(
  parameter int AW  = 32,
  parameter int SKW = 5
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            enable_i,
  input  logic            soft_rst_i,
  input  logic            poll_i,
  input  logic            dir_tx_i,
  input  logic [AW-1:0]   base_addr_i,
  input  logic [SKW-1:0]  skip_words_i,
  output logic            mem_req_o,
  output logic            mem_we_o,
  output logic [AW-1:0]   mem_addr_o,
  output logic [31:0]     mem_wdata_o,
  input  logic            mem_ack_i,
  input  logic [31:0]     mem_rdata_i,
  output logic            xfer_req_o,
  output logic [AW-1:0]   xfer_addr_o,
  output logic [SZ_W-1:0] xfer_len_o,
  input  logic            xfer_done_i,
  output logic            busy_o,
  output logic            tx_done_o,
  output logic            rx_done_o,
  output logic            dsc_unavail_o,
  output logic            card_err_o
);
  localparam int WIW = $clog2(DESC_WORDS);
  localparam int NFLAG = 4;

  walk_state_e    st_q;
  logic [WIW-1:0] widx_q;
  logic [31:0]    wrd_q [DESC_WORDS];
  logic [AW-1:0]  cur;
  logic [SZ_W-1:0] size1, size2;
  logic           need1, need2, chain, go, start, advance;
  logic           own_miss, own_hit, done_set;
  logic [NFLAG-1:0] set_v, flag_v;
  logic           unused_sz_hi;

  assign chain        = wrd_q[0][CB_CHAIN];
  assign size1        = wrd_q[1][SZ_W-1:0];
  assign size2        = wrd_q[1][2*SZ_W-1:SZ_W];
  assign unused_sz_hi = ^wrd_q[1][31:2*SZ_W];
  assign need1        = size1 != '0;
  assign need2        = !chain && (size2 != '0);
  assign go           = enable_i && poll_i && !soft_rst_i;
  assign start        = (st_q == ST_IDLE) && go;
  assign advance      = (st_q == ST_WB) && mem_ack_i && !soft_rst_i;

  assign own_miss = (st_q == ST_FETCH) && mem_ack_i && (widx_q == '0) && !mem_rdata_i[CB_OWN];
  assign own_hit  = (st_q == ST_FETCH) && mem_ack_i && (widx_q == '0) && mem_rdata_i[CB_OWN];
  assign done_set = advance && wrd_q[0][CB_LAST] && !wrd_q[0][CB_INT_OFF];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      widx_q <= '0;
      for (int i = 0; i < DESC_WORDS; i++) wrd_q[i] <= '0;
    end else if (soft_rst_i) begin
      st_q   <= ST_IDLE;
      widx_q <= '0;
    end else begin
      case (st_q)
        ST_IDLE: if (go) begin
          st_q   <= ST_FETCH;
          widx_q <= '0;
        end
        ST_FETCH: if (mem_ack_i) begin
          wrd_q[widx_q] <= mem_rdata_i;
          if (own_miss) begin
            st_q <= ST_SUSP;
          end else begin
            widx_q <= widx_q + 1'b1;
            if (widx_q == WIW'(DESC_WORDS - 1)) st_q <= ST_BUF1;
          end
        end
        ST_SUSP: if (go) st_q <= ST_FETCH;
        ST_BUF1: if (!need1 || xfer_done_i) st_q <= ST_BUF2;
        ST_BUF2: if (!need2 || xfer_done_i) st_q <= ST_WB;
        ST_WB: if (mem_ack_i) begin
          st_q   <= wrd_q[0][CB_LAST] ? ST_IDLE : ST_FETCH;
          widx_q <= '0;
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  dw_ptr #(.AW(AW), .SKW(SKW)) u_ptr (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .soft_rst_i (soft_rst_i),
    .base_i     (base_addr_i),
    .skip_i     (skip_words_i),
    .start_i    (start),
    .advance_i  (advance),
    .chain_i    (chain),
    .eor_i      (wrd_q[0][CB_EOR]),
    .next_ptr_i (AW'(wrd_q[3])),
    .cur_o      (cur)
  );

  assign set_v = {own_hit && mem_rdata_i[CB_CERR], own_miss,
                  done_set && !dir_tx_i, done_set && dir_tx_i};

  dw_flags #(.NF(NFLAG)) u_flags (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .soft_rst_i (soft_rst_i),
    .set_i      (set_v),
    .flag_o     (flag_v)
  );

  assign tx_done_o     = flag_v[0];
  assign rx_done_o     = flag_v[1];
  assign dsc_unavail_o = flag_v[2];
  assign card_err_o    = flag_v[3];

  assign busy_o      = st_q != ST_IDLE;
  assign mem_req_o   = (st_q == ST_FETCH) || (st_q == ST_WB);
  assign mem_we_o    = st_q == ST_WB;
  assign mem_addr_o  = (st_q == ST_WB) ? cur : cur + AW'({widx_q, 2'b00});
  assign mem_wdata_o = {1'b0, wrd_q[0][30:0]};

  assign xfer_req_o  = ((st_q == ST_BUF1) && need1) || ((st_q == ST_BUF2) && need2);
  assign xfer_addr_o = (st_q == ST_BUF2) ? AW'(wrd_q[3]) : AW'(wrd_q[2]);
  assign xfer_len_o  = (st_q == ST_BUF2) ? size2 : size1;

  // R2
  mem_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && !mem_ack_i && !soft_rst_i |=> mem_req_o && $stable(mem_addr_o));
  // R4
  xfer_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    xfer_req_o && !xfer_done_i && !soft_rst_i |=> xfer_req_o && $stable(xfer_addr_o));
  // R6
  zero_len_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    xfer_req_o |-> xfer_len_o != '0);
  // R3
  unavail_stop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(dsc_unavail_o) |-> !mem_req_o && busy_o);
  // R10
  tx_after_wb_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(tx_done_o) |-> $past(mem_req_o && mem_we_o && mem_ack_i));
endmodule

// File: tb/dsc_walker_test.sv
module dsc_walker_test;
  localparam int CLK_PERIOD = 10;

  typedef struct packed {
    logic [31:0] ctl; logic [31:0] sz; logic [31:0] w2; logic [31:0] w3;
    logic dir; logic [1:0] n;
    logic [31:0] a0; logic [12:0] l0; logic [31:0] a1; logic [12:0] l1;
    logic tx; logic rx; logic ce;
  } vec_t;

  // own=bit31 cerr=bit30 eor=bit5 chain=bit4 last=bit2 intoff=bit1; sizes: b1 12:0, b2 25:13
  localparam vec_t VECS [5] = '{
    '{32'h8000000C, 32'h00040100, 32'h1000, 32'h2000, 1'b1, 2'd2, 32'h1000, 13'h100, 32'h2000, 13'h020, 1'b1, 1'b0, 1'b0},
    '{32'h80000014, 32'h00080080, 32'h3000, 32'h0000, 1'b0, 2'd1, 32'h3000, 13'h080, 32'h0,    13'h0,   1'b0, 1'b1, 1'b0},
    '{32'h80000004, 32'h00400000, 32'h4000, 32'h5000, 1'b1, 2'd1, 32'h5000, 13'h200, 32'h0,    13'h0,   1'b1, 1'b0, 1'b0},
    '{32'h80000006, 32'h00001000, 32'h6000, 32'h7000, 1'b1, 2'd1, 32'h6000, 13'h1000,32'h0,    13'h0,   1'b0, 1'b0, 1'b0},
    '{32'hC0000004, 32'h00000004, 32'h8000, 32'h9000, 1'b0, 2'd1, 32'h8000, 13'h004, 32'h0,    13'h0,   1'b0, 1'b1, 1'b1}
  };

  logic clk = 0, rst_n = 0;
  logic enable = 0, soft_rst = 0, poll = 0, dir_tx = 0;
  logic [31:0] base = 32'h40;
  logic [4:0]  skip = 0;
  logic mem_req, mem_we, mem_ack = 0, xfer_req, xfer_done = 0, busy;
  logic [31:0] mem_addr, mem_wdata, mem_rdata, xfer_addr;
  logic [12:0] xfer_len;
  logic tx_done, rx_done, unavail, cerr;

  logic [31:0] mem [64];
  logic        ld_en = 0;
  logic [5:0]  ld_idx = 0;
  logic [31:0] ld_data = 0;
  logic [31:0] rd_log [256];
  logic [31:0] xa_log [256];
  logic [12:0] xl_log [256];
  int rd_cnt = 0, x_cnt = 0, xwait = 0;
  int checks = 0, fails = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dsc_walker uut (
    .clk_i(clk), .rst_ni(rst_n), .enable_i(enable), .soft_rst_i(soft_rst),
    .poll_i(poll), .dir_tx_i(dir_tx), .base_addr_i(base), .skip_words_i(skip),
    .mem_req_o(mem_req), .mem_we_o(mem_we), .mem_addr_o(mem_addr),
    .mem_wdata_o(mem_wdata), .mem_ack_i(mem_ack), .mem_rdata_i(mem_rdata),
    .xfer_req_o(xfer_req), .xfer_addr_o(xfer_addr), .xfer_len_o(xfer_len),
    .xfer_done_i(xfer_done), .busy_o(busy), .tx_done_o(tx_done),
    .rx_done_o(rx_done), .dsc_unavail_o(unavail), .card_err_o(cerr)
  );

  assign mem_rdata = mem[mem_addr[7:2]];

  always @(posedge clk) begin
    if (ld_en) mem[ld_idx] <= ld_data;
    if (mem_ack && mem_we) mem[mem_addr[7:2]] <= mem_wdata;
    if (mem_ack && !mem_we) begin
      rd_log[rd_cnt[7:0]] <= mem_addr;
      rd_cnt <= rd_cnt + 1;
    end
    mem_ack <= rst_n && mem_req && !mem_ack;
    if (xfer_done) xfer_done <= 1'b0;
    else if (xfer_req) begin
      if (xwait == 2) begin
        xfer_done <= 1'b1;
        xwait <= 0;
        xa_log[x_cnt[7:0]] <= xfer_addr;
        xl_log[x_cnt[7:0]] <= xfer_len;
        x_cnt <= x_cnt + 1;
      end else xwait <= xwait + 1;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic put(input logic [31:0] addr, input logic [31:0] data);
    @(negedge clk); ld_en = 1; ld_idx = addr[7:2]; ld_data = data;
    @(negedge clk); ld_en = 0;
  endtask

  task automatic put_desc(input logic [31:0] a, input logic [31:0] c, s, p1, p2);
    put(a, c); put(a + 4, s); put(a + 8, p1); put(a + 12, p2);
  endtask

  task automatic pulse_poll();
    @(negedge clk); poll = 1;
    @(negedge clk); poll = 0;
  endtask

  task automatic pulse_soft();
    @(negedge clk); soft_rst = 1;
    @(negedge clk); soft_rst = 0;
  endtask

  task automatic wait_idle(input string req);
    int n = 0;
    while (busy && n < 5000) begin @(negedge clk); n++; end
    chk(req, {31'd0, busy}, 32'd0);
  endtask

  task automatic wait_unavail(input string req);
    int n = 0;
    while (!unavail && n < 5000) begin @(negedge clk); n++; end
    chk(req, {31'd0, unavail}, 32'd1);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks + 1, fails + 1);
    $finish;
  end

  initial begin
    int r0, x0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk("R1 reset outputs", {27'd0, busy, mem_req, xfer_req, tx_done | rx_done, unavail | cerr}, 32'd0);

    // R2 poll ignored while disabled
    r0 = rd_cnt;
    pulse_poll();
    repeat (10) @(negedge clk);
    chk("R2 disabled poll busy", {31'd0, busy}, 32'd0);
    chk("R2 disabled poll reads", rd_cnt - r0, 0);
    enable = 1;

    // table of single-descriptor cases at base
    for (int v = 0; v < 5; v++) begin
      pulse_soft();
      put_desc(32'h40, VECS[v].ctl, VECS[v].sz, VECS[v].w2, VECS[v].w3);
      dir_tx = VECS[v].dir;
      r0 = rd_cnt; x0 = x_cnt;
      pulse_poll();
      wait_idle("R10 vector goes idle");
      chk("R2 fetch order w0", rd_log[r0[7:0]], 32'h40);
      chk("R2 fetch order w3", rd_log[8'(r0 + 3)], 32'h4C);
      chk("R5 R6 transfer count", x_cnt - x0, {30'd0, VECS[v].n});
      chk("R4 first addr", xa_log[x0[7:0]], VECS[v].a0);
      chk("R4 R6 first len", {19'd0, xl_log[x0[7:0]]}, {19'd0, VECS[v].l0});
      if (VECS[v].n == 2) begin
        chk("R5 second addr", xa_log[8'(x0 + 1)], VECS[v].a1);
        chk("R5 second len", {19'd0, xl_log[8'(x0 + 1)]}, {19'd0, VECS[v].l1});
      end
      chk("R7 write-back", mem[16], VECS[v].ctl & 32'h7FFFFFFF);
      chk("R10 tx flag", {31'd0, tx_done}, {31'd0, VECS[v].tx});
      chk("R10 rx flag", {31'd0, rx_done}, {31'd0, VECS[v].rx});
      chk("R11 card error", {31'd0, cerr}, {31'd0, VECS[v].ce});
    end

    // R3 unowned descriptor suspends, poll resumes
    pulse_soft();
    put_desc(32'h40, 32'h00000004, 32'h8, 32'hA00, 32'h0);
    r0 = rd_cnt; x0 = x_cnt;
    pulse_poll();
    wait_unavail("R3 unavailable flag");
    repeat (5) @(negedge clk);
    chk("R3 single read", rd_cnt - r0, 1);
    chk("R3 suspended busy", {31'd0, busy}, 32'd1);
    chk("R3 no transfer", x_cnt - x0, 0);
    put(32'h40, 32'h80000004);
    pulse_poll();
    wait_idle("R3 resume completes");
    chk("R3 refetch address", rd_log[8'(r0 + 1)], 32'h40);
    chk("R3 resumed transfer", x_cnt - x0, 1);

    // R8 ring advance with skip, R10 continue without poll
    pulse_soft();
    skip = 5'd3;
    put_desc(32'h40, 32'h80000000, 32'h8, 32'hB00, 32'h0);
    put_desc(32'h5C, 32'h80000004, 32'h10, 32'hB10, 32'h0);
    r0 = rd_cnt; x0 = x_cnt;
    pulse_poll();
    wait_idle("R10 two descriptors idle");
    chk("R8 skip address", rd_log[8'(r0 + 4)], 32'h5C);
    chk("R10 continued transfers", x_cnt - x0, 2);
    chk("R8 second buffer", xa_log[8'(x0 + 1)], 32'hB10);
    skip = 5'd0;

    // R8 end of ring back to base
    pulse_soft();
    put_desc(32'h40, 32'h80000020, 32'h4, 32'hC00, 32'h0);
    r0 = rd_cnt;
    pulse_poll();
    wait_unavail("R8 wrap hits returned descriptor");
    chk("R8 wrap address", rd_log[8'(r0 + 4)], 32'h40);

    // R9 chained next pointer, no buffer 2
    pulse_soft();
    put_desc(32'h40, 32'h80000010, 32'h00040004, 32'hD00, 32'hA0);
    put_desc(32'hA0, 32'h80000014, 32'h8, 32'hD10, 32'h0);
    r0 = rd_cnt; x0 = x_cnt;
    pulse_poll();
    wait_idle("R9 chain idle");
    chk("R9 next pointer", rd_log[8'(r0 + 4)], 32'hA0);
    chk("R5 chained single buffers", x_cnt - x0, 2);
    chk("R9 second buffer", xa_log[8'(x0 + 1)], 32'hD10);

    // R12 stickiness, R10 resume at advanced address, R1 base reload
    pulse_soft();
    dir_tx = 1;
    put_desc(32'h40, 32'h80000004, 32'h4, 32'hE00, 32'h0);
    put_desc(32'h50, 32'h80000006, 32'h4, 32'hE10, 32'h0);
    pulse_poll();
    wait_idle("R10 first run");
    r0 = rd_cnt;
    pulse_poll();
    wait_idle("R10 second run");
    chk("R10 next poll continues", rd_log[r0[7:0]], 32'h50);
    chk("R12 tx stays set", {31'd0, tx_done}, 32'd1);
    pulse_soft();
    chk("R1 soft reset clears", {28'd0, tx_done, rx_done, unavail, cerr}, 32'd0);
    base = 32'h80;
    put_desc(32'h80, 32'h80000004, 32'h4, 32'hF00, 32'h0);
    r0 = rd_cnt;
    pulse_poll();
    wait_idle("R1 new base run");
    chk("R1 base reload", rd_log[r0[7:0]], 32'h80);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule